// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between an asynchronous UART core and an infrared transceiver. On the transmit side it watches the UART's NRZ output. For every logical-0 bit it emits one short high pulse on the infrared output. A logical-1 bit leaves the output low for the whole bit. The pulse width is 3/16 of a bit and comes from one of two sources. The first is the UART's 16x baud enable, which gives a pulse of 3 ticks. The second is a fixed reference clock that an internal prescaler derives from the peripheral clock. That reference period is 2N+2 peripheral cycles, where N is a 4-bit clock-select input.

On the receive side the block first applies a selectable polarity correction. It then synchronizes the pin with two flip-flops and stretches each detected pulse rising edge into a low NRZ level 16 baud ticks long. An 8-bit control register holds three bits: the mode enable, the width-source select and the receive-polarity select. While the mode enable is clear, both directions pass straight through. A registered error flag reports when infrared mode is enabled while the UART signals synchronous framing.

Top module: `irsir_codec`

## Requirements
- R1: After reset the control register reads 0x00, the configuration-error flag is 0, and ir_txd follows uart_txd.
- R2: A write stores wdata bits 7 (mode enable), 6 (width select) and 5 (polarity select). Read data bits 4..0 always read 0, whatever value is written to them.
- R3: With bit 7 clear, ir_txd equals uart_txd and uart_rxd equals ir_rxd, with no pulse shaping.
- R4: With bit 7 set and bit 6 clear, a 0 bit sampled on a baud tick raises ir_txd at that tick for exactly 3 tick periods. A 1 bit produces no pulse.
- R5: With bits 7 and 6 set, each 0 bit raises ir_txd for exactly 3*(2N+2) peripheral cycles, counted from the tick that starts the bit. N is the clk_sel value.
- R6: With bit 5 clear the receive pin is inverted before decoding. With bit 5 set it is used unchanged.
- R7: In infrared mode a rising edge of the corrected receive signal drives uart_rxd low. uart_rxd returns high on the 16th baud tick after that edge.
- R8: The cfg_err output is 1 one cycle after bit 7 is set while sync_mode is high. It is 0 otherwise.
- R9: Back-to-back 0 bits produce one pulse each, spaced 16 ticks apart. A byte framed with a start bit and a stop bit, looped back to the receive pin, decodes to the same NRZ levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | 16x baud enable from the UART, one cycle wide |
| sync_mode | input | 1 | High when the UART uses synchronous framing |
| clk_sel | input | 4 | N for the reference clock, period 2N+2 cycles |
| uart_txd | input | 1 | NRZ transmit data from the UART |
| ir_rxd | input | 1 | Receive pin from the transceiver |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| ir_txd | output | 1 | Pulse output to the transceiver |
| uart_rxd | output | 1 | NRZ receive data to the UART |
| cfg_err | output | 1 | Infrared mode enabled with synchronous framing |

## Verification
The hardest case to reach is a fixed-width pulse that must line up with the prescaler. A free-running reference clock would shorten the first period by a random phase. The stimulus therefore draws a new N at random for each byte, including the end values 0 and 15. It measures every pulse in peripheral cycles against 3*(2N+2). Bytes of all zeros run 0 bits back to back, so one stretch ends in the same cycle range as the next pulse begins. The loopback in both polarity settings checks that each bit still decodes correctly at its midpoint.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
  localparam int CTRL_W   = 8;
  localparam int EN_BIT   = 7;
  localparam int WSEL_BIT = 6;
  localparam int POL_BIT  = 5;

  typedef struct packed {
    logic en;    // infrared mode
    logic wsel;  // 1: fixed reference width, 0: baud width
    logic pol;   // 0: invert receive pin, 1: pass
  } ir_ctrl_t;
endpackage

// File: rtl/irsir_ctrl_reg.sv
module irsir_ctrl_reg
  import irsir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output ir_ctrl_t          ctrl,
  output logic [CTRL_W-1:0] rdata
);
  ir_ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we) begin
      ctrl_d.en   = wdata[EN_BIT];
      ctrl_d.wsel = wdata[WSEL_BIT];
      ctrl_d.pol  = wdata[POL_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  always_comb begin
    rdata           = '0;
    rdata[EN_BIT]   = ctrl_q.en;
    rdata[WSEL_BIT] = ctrl_q.wsel;
    rdata[POL_BIT]  = ctrl_q.pol;
  end

  assign ctrl = ctrl_q;

  // R2
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata[7:5] == $past(wdata[7:5])));
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (|wdata[4:0])) |=> (rdata[4:0] == '0));
endmodule

// File: rtl/irsir_prescaler.sv
module irsir_prescaler #(
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [NW-1:0] nsel,
  output logic          ref_tick
);
  localparam int CW = NW + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] limit;

  assign limit    = {nsel, 1'b1};      // 2N+1
  assign ref_tick = (cnt_q == limit);

  always_comb begin
    if (restart)       cnt_d = '0;
    else if (ref_tick) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5
  ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |=> !ref_tick);
endmodule

// File: rtl/irsir_tx_enc.sv
module irsir_tx_enc #(
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_UNITS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic wsel,
  input  logic tick16,
  input  logic txd,
  input  logic ref_tick,
  output logic restart,
  output logic pulse
);
  localparam int BW = $clog2(TICKS_PER_BIT);
  localparam int RW = $clog2(PULSE_UNITS + 1);
  localparam logic [BW-1:0] LAST_TICK = BW'(TICKS_PER_BIT - 1);
  localparam logic [BW-1:0] END_TICK  = BW'(PULSE_UNITS);
  localparam logic [RW-1:0] END_REF   = RW'(PULSE_UNITS - 1);

  logic          busy_q, busy_d;
  logic [BW-1:0] bcnt_q, bcnt_d;
  logic          pulse_q, pulse_d;
  logic [RW-1:0] rcnt_q, rcnt_d;
  logic          start;

  assign start   = en && tick16 && !busy_q && !txd;
  assign restart = start;

  always_comb begin
    busy_d  = busy_q;
    bcnt_d  = bcnt_q;
    pulse_d = pulse_q;
    rcnt_d  = rcnt_q;
    if (!en) begin
      busy_d  = 1'b0;
      pulse_d = 1'b0;
    end else if (start) begin
      busy_d  = 1'b1;
      bcnt_d  = BW'(1);
      pulse_d = 1'b1;
      rcnt_d  = '0;
    end else begin
      if (busy_q && tick16) begin
        bcnt_d = bcnt_q + 1'b1;
        if (bcnt_q == LAST_TICK) busy_d = 1'b0;
      end
      if (pulse_q) begin
        if (!wsel && tick16 && busy_q && bcnt_q == END_TICK) pulse_d = 1'b0;
        if (wsel && ref_tick) begin
          rcnt_d = rcnt_q + 1'b1;
          if (rcnt_q == END_REF) pulse_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      bcnt_q  <= '0;
      pulse_q <= 1'b0;
      rcnt_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      bcnt_q  <= bcnt_d;
      pulse_q <= pulse_d;
      rcnt_q  <= rcnt_d;
    end
  end

  assign pulse = pulse_q;

  // R4
  pulse_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(!txd && tick16 && en));
  // R3
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pulse_q);
endmodule

// File: rtl/irsir_rx_dec.sv
module irsir_rx_dec #(
  parameter int SYNC_STAGES   = 2,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pol,
  input  logic tick16,
  input  logic pin,
  output logic low_out
);
  localparam int CW = $clog2(TICKS_PER_BIT);
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

  logic                   corr;
  logic [SYNC_STAGES-1:0] sy_q;
  logic                   prev_q;
  logic                   rise;
  logic                   str_q, str_d;
  logic [CW-1:0]          cnt_q, cnt_d;

  assign corr = pol ? pin : ~pin;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    logic d;
    if (i == 0) begin : g_first
      assign d = corr;
    end else begin : g_next
      assign d = sy_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sy_q[i] <= 1'b0;
      else        sy_q[i] <= d;
    end
  end

  assign rise = sy_q[SYNC_STAGES-1] && !prev_q;

  always_comb begin
    str_d = str_q;
    cnt_d = cnt_q;
    if (!en) begin
      str_d = 1'b0;
    end else if (rise) begin
      str_d = 1'b1;
      cnt_d = '0;
    end else if (str_q && tick16) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) str_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      str_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= sy_q[SYNC_STAGES-1];
      str_q  <= str_d;
      cnt_q  <= cnt_d;
    end
  end

  assign low_out = str_q;

  // R7
  stretch_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(str_q) |-> $past(tick16 || !en));
endmodule

// File: rtl/irsir_codec.sv
module irsir_codec
  import irsir_pkg::*;
#(
  parameter int NW            = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_UNITS   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              sync_mode,
  input  logic [NW-1:0]     clk_sel,
  input  logic              uart_txd,
  input  logic              ir_rxd,
  input  logic              reg_we,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  output logic              ir_txd,
  output logic              uart_rxd,
  output logic              cfg_err
);
  logic [1:0] rs_q;
  logic       rst_s_n;
  ir_ctrl_t   ctrl;
  logic       ref_tick;
  logic       restart;
  logic       tx_pulse;
  logic       rx_low;
  logic       err_q, err_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  irsir_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .we(reg_we), .wdata(reg_wdata),
    .ctrl(ctrl), .rdata(reg_rdata)
  );

  irsir_prescaler #(.NW(NW)) u_pre (
    .clk(clk), .rst_n(rst_s_n), .restart(restart), .nsel(clk_sel),
    .ref_tick(ref_tick)
  );

  irsir_tx_enc #(.TICKS_PER_BIT(TICKS_PER_BIT), .PULSE_UNITS(PULSE_UNITS)) u_tx (
    .clk(clk), .rst_n(rst_s_n), .en(ctrl.en), .wsel(ctrl.wsel),
    .tick16(tick16), .txd(uart_txd), .ref_tick(ref_tick),
    .restart(restart), .pulse(tx_pulse)
  );

  irsir_rx_dec #(.SYNC_STAGES(SYNC_STAGES), .TICKS_PER_BIT(TICKS_PER_BIT)) u_rx (
    .clk(clk), .rst_n(rst_s_n), .en(ctrl.en), .pol(ctrl.pol),
    .tick16(tick16), .pin(ir_rxd), .low_out(rx_low)
  );

  assign err_d = ctrl.en && sync_mode;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) err_q <= 1'b0;
    else          err_q <= err_d;
  end

  assign cfg_err  = err_q;
  assign ir_txd   = ctrl.en ? tx_pulse : uart_txd;
  assign uart_rxd = ctrl.en ? ~rx_low  : ir_rxd;

  // R8
  cfg_err_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reg_rdata[EN_BIT] && sync_mode) |=> cfg_err);
  // R3
  pass_rx_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !reg_rdata[EN_BIT] |-> (uart_rxd == ir_rxd));
endmodule

// File: tb/irsir_codec_tb.sv
module irsir_codec_tb;
  localparam int TP = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       sync_mode = 1'b0;
  logic [3:0] clk_sel = 4'd0;
  logic       uart_txd = 1'b1;
  logic       rx_drv = 1'b1;
  logic       loop_on = 1'b0;
  logic       pol_bit = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ir_txd, uart_rxd, cfg_err, ir_rxd;

  int checks = 0, fails = 0;
  bit done = 0;
  bit mon_on = 0;
  int mon_w = 0, mon_cnt = 0, exp_w = 0;

  always #4 clk = ~clk;

  assign ir_rxd = loop_on ? (pol_bit ? ir_txd : ~ir_txd) : rx_drv;

  irsir_codec u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .sync_mode(sync_mode),
    .clk_sel(clk_sel), .uart_txd(uart_txd), .ir_rxd(ir_rxd),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ir_txd(ir_txd), .uart_rxd(uart_rxd), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // pulse width monitor, R4 / R5
  always @(negedge clk) begin
    if (mon_on) begin
      if (ir_txd) mon_w++;
      else if (mon_w != 0) begin
        mon_cnt++;
        chk(mon_w == exp_w, "R4/R5 pulse width", mon_w, exp_w);
        mon_w = 0;
      end
    end else mon_w = 0;
  end

  function automatic int zeros_in(input logic [7:0] b);
    int z = 0;
    for (int i = 0; i < 8; i++) if (!b[i]) z++;
    return z;
  endfunction

  function automatic int fixed_width(input logic [3:0] n);
    return 3 * (2 * int'(n) + 2);
  endfunction

  task automatic one_tick();
    @(negedge clk) tick16 = 1'b1;
    @(negedge clk) tick16 = 1'b0;
    repeat (TP - 2) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk) begin reg_we = 1'b1; reg_wdata = v; end
    @(negedge clk) reg_we = 1'b0;
  endtask

  // R9: frame a byte, check pulse count and midpoint decode
  task automatic send_byte(input logic [7:0] b);
    logic [9:0] fr;
    fr = {1'b1, b, 1'b0};
    mon_cnt = 0;
    for (int i = 0; i < 10; i++) begin
      uart_txd = fr[i];
      for (int t = 0; t < 16; t++) begin
        one_tick();
        if (t == 8) chk(uart_rxd == fr[i], "R9 decoded bit", uart_rxd, fr[i]);
      end
    end
    repeat (8) one_tick();
    chk(mon_cnt == zeros_in(b) + 1, "R9 pulse count", mon_cnt, zeros_in(b) + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1
    chk(reg_rdata == 8'h00, "R1 reset rdata", reg_rdata, 0);
    chk(cfg_err == 1'b0, "R1 reset cfg_err", cfg_err, 0);
    chk(ir_txd == uart_txd, "R1 reset ir_txd", ir_txd, uart_txd);

    // R2
    wr(8'hFF); @(negedge clk);
    chk(reg_rdata == 8'hE0, "R2 readback", reg_rdata, 8'hE0);
    wr(8'h5F); @(negedge clk);
    chk(reg_rdata == 8'h40, "R2 readback", reg_rdata, 8'h40);
    wr(8'h00); @(negedge clk);
    chk(reg_rdata == 8'h00, "R2 readback", reg_rdata, 0);

    // R3
    for (int k = 0; k < 8; k++) begin
      @(negedge clk) begin uart_txd = $urandom(); rx_drv = $urandom(); end
      @(negedge clk);
      chk(ir_txd == uart_txd, "R3 tx pass", ir_txd, uart_txd);
      chk(uart_rxd == rx_drv, "R3 rx pass", uart_rxd, rx_drv);
    end
    uart_txd = 1'b1;

    // R8
    wr(8'h80);
    sync_mode = 1'b1;
    repeat (2) @(negedge clk);
    chk(cfg_err == 1'b1, "R8 error set", cfg_err, 1);
    sync_mode = 1'b0;
    repeat (2) @(negedge clk);
    chk(cfg_err == 1'b0, "R8 error clear", cfg_err, 0);
    wr(8'h00);
    sync_mode = 1'b1;
    repeat (2) @(negedge clk);
    chk(cfg_err == 1'b0, "R8 no error when off", cfg_err, 0);
    sync_mode = 1'b0;

    // R7 directed stretch, pol pass-through
    rx_drv = 1'b0;
    wr(8'hA0);
    repeat (4) @(negedge clk);
    rx_drv = 1'b1;
    repeat (3) @(negedge clk);
    rx_drv = 1'b0;
    repeat (3) @(negedge clk);
    chk(uart_rxd == 1'b0, "R7 stretch start", uart_rxd, 0);
    repeat (15) one_tick();
    chk(uart_rxd == 1'b0, "R7 still low after 15 ticks", uart_rxd, 0);
    one_tick();
    chk(uart_rxd == 1'b1, "R7 high after 16 ticks", uart_rxd, 1);

    // R6 polarity: pin held low, pol=1 -> nothing, pol=0 -> inverted edge
    repeat (20) one_tick();
    chk(uart_rxd == 1'b1, "R6 no edge with pol set", uart_rxd, 1);
    wr(8'h80);
    repeat (5) @(negedge clk);
    chk(uart_rxd == 1'b0, "R6 inverted pin decoded", uart_rxd, 0);
    repeat (17) one_tick();
    rx_drv = 1'b1;

    // R4 baud width, loopback, both polarities
    exp_w = 3 * TP;
    for (int p = 0; p < 2; p++) begin
      pol_bit = p[0];
      wr(p == 1 ? 8'hA0 : 8'h80);
      loop_on = 1'b1;
      repeat (20) one_tick();
      mon_on = 1;
      send_byte(8'h00);
      send_byte(8'hFF);
      for (int k = 0; k < 3; k++) send_byte(8'($urandom()));
      mon_on = 0;
      loop_on = 1'b0;
    end

    // R5 fixed width, random N, both polarities
    for (int p = 0; p < 2; p++) begin
      pol_bit = p[0];
      wr(p == 1 ? 8'hE0 : 8'hC0);
      loop_on = 1'b1;
      repeat (20) one_tick();
      mon_on = 1;
      for (int k = 0; k < 4; k++) begin
        clk_sel = (k == 0) ? 4'd0 : (k == 1) ? 4'd15 : 4'($urandom());
        exp_w = fixed_width(clk_sel);
        b = (k == 1) ? 8'h00 : 8'($urandom());
        send_byte(b);
      end
      mon_on = 0;
      loop_on = 1'b0;
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule